// File: doc/BRIEF.md
# Multi-Station Phase Rotation Summer

This block forms one phased beam from many antenna stations. Every station delivers a signed complex sample in the same clock cycle, qualified by one shared valid strobe. A per-station phase accumulator advances by a programmable rate on each valid sample. The top bits of the accumulator pick a cosine and a sine value from a fixed trigonometric table. A complex multiplier turns the station's sample by that angle, and the product is rounded back to a narrow word. A registered binary adder tree then adds all rotated samples into one wide complex result per valid input.

Software, or a control block beside it, sets two values for each station through a single write port: the phase rate and the initial phase. A sync strobe loads every accumulator with its initial phase at the same instant, which lines up the phase ramps of all stations. The pipeline is fixed, so each result leaves a known number of cycles after its input arrived.

Top module: `phase_summer`

## Requirements
- R1: After reset, `out_valid` is low and `out_re`/`out_im` are zero, and every rate and initial phase is zero. A sample presented with no write and no sync is therefore rotated by phase 0.
- R2: `out_valid` is `in_valid` delayed by exactly 8 cycles: 1 table stage, 2 multiply stages and 5 adder levels. Every valid input yields exactly one output, in order, and gaps are preserved.
- R3: Table entry k (k = 0..255) holds sin(k) = round(127·16q/(81920−4q)) with q = m(128−m) and m = k mod 128, negated for k ≥ 128 (two's complement, 8 bits). cos(k) = sin((k+64) mod 256), so phase 0 gives cos = 127 and sin = 0.
- R4: A station with sample a + jb and table values c, s gives rotated real part (a·c − b·s + 64) >>> 7 and imaginary part (a·s + b·c + 64) >>> 7, as 9-bit signed values.
- R5: `out_re`/`out_im` equal the exact sum of the 32 rotated real and imaginary parts as 14-bit signed values, with no wrap for any input, including all stations at −128.
- R6: The table index for a sample is bits [15:8] of the 16-bit phase used for it. On each valid sample the accumulator becomes that phase plus the station rate, modulo 2^16. Cycles without valid and without sync leave it unchanged.
- R7: While `sync` is high, the phase used is the station's initial phase instead of the accumulator. The accumulator then becomes initial + rate if `in_valid` is high, and the initial phase otherwise.
- R8: A write with `wr_en` high loads `wr_data` into the rate (`wr_sel` = 0) or the initial phase (`wr_sel` = 1) of station `wr_sta` only. It governs samples from the next cycle on. Writing an initial phase does not move an accumulator until the next sync.
- R9: While `out_valid` is low, `out_re` and `out_im` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | All station samples valid this cycle |
| in_re | input | 256 | Real parts, station i at bits [8i+7:8i], signed |
| in_im | input | 256 | Imaginary parts, same packing |
| sync | input | 1 | Load all accumulators with their initial phases |
| wr_en | input | 1 | Parameter write strobe |
| wr_sta | input | 5 | Station addressed by the write |
| wr_sel | input | 1 | 0 = phase rate, 1 = initial phase |
| wr_data | input | 16 | Value written |
| out_valid | output | 1 | Phased result valid |
| out_re | output | 14 | Summed real part, signed |
| out_im | output | 14 | Summed imaginary part, signed |

## Verification
The bench streams random samples while every station runs a different rate. This walks the tables through every quadrant, so a sign slip in the quarter-wave fold or a swapped sine and cosine shows up as a wrong sum. Syncs are applied both with and without a valid sample. A design that added the rate before using the phase, or ignored sync when valid was low, would drift by one step against the model. Runs of back-to-back samples and irregular gaps expose a valid pipe one stage off, or an accumulator that steps on idle cycles. All-negative full-scale inputs at phases 0 and 128 catch rounding toward zero and any wrap in the 14-bit sum.

// File: rtl/phs_pkg.sv
package phs_pkg;

  // Integer half-wave sine approximation, amplitude amp, 2**phw points per turn.
  function automatic int trig_entry(input int idx, input int phw, input int amp);
    int h;
    int p;
    int m;
    int q;
    int den;
    int v;
    h   = 2 ** (phw - 1);
    p   = idx % (2 * h);
    m   = p % h;
    q   = m * (h - m);
    den = 5 * h * h - 4 * q;
    v   = (16 * q * amp + den / 2) / den;
    return (p >= h) ? -v : v;
  endfunction

endpackage

// File: rtl/phs_trig_rom.sv
module phs_trig_rom #(
  parameter int PHW = 8,
  parameter int TW  = 8
) (
  output logic signed [TW-1:0] cos_t [2**PHW],
  output logic signed [TW-1:0] sin_t [2**PHW]
);
  localparam int DEPTH = 2 ** PHW;
  localparam int QTR   = DEPTH / 4;
  localparam int AMP   = 2 ** (TW - 1) - 1;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign sin_t[e] = TW'(phs_pkg::trig_entry(e, PHW, AMP));
    assign cos_t[e] = TW'(phs_pkg::trig_entry(e + QTR, PHW, AMP));
  end
endmodule

// File: rtl/phs_phase_gen.sv
module phs_phase_gen #(
  parameter int ACCW = 16,
  parameter int PHW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            sync,
  input  logic            wr_rate,
  input  logic            wr_init,
  input  logic [ACCW-1:0] wr_data,
  output logic [PHW-1:0]  phase
);
  logic [ACCW-1:0] acc_q, acc_d;
  logic [ACCW-1:0] rate_q, init_q;
  logic [ACCW-1:0] base;
  logic            acc_en;

  always_comb begin
    base   = sync ? init_q : acc_q;
    acc_d  = base + (in_valid ? rate_q : '0);
    acc_en = sync | in_valid;
  end

  assign phase = base[ACCW-1 -: PHW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rate_q <= '0;
      init_q <= '0;
    end else begin
      if (acc_en)  acc_q  <= acc_d;
      if (wr_rate) rate_q <= wr_data;
      if (wr_init) init_q <= wr_data;
    end
  end
endmodule

// File: rtl/phs_rotator.sv
module phs_rotator #(
  parameter int SW  = 8,
  parameter int TW  = 8,
  parameter int PHW = 8,
  parameter int RW  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_tab,
  input  logic                 ld_mul,
  input  logic                 ld_rnd,
  input  logic [PHW-1:0]       phase,
  input  logic signed [SW-1:0] s_re,
  input  logic signed [SW-1:0] s_im,
  input  logic signed [TW-1:0] cos_t [2**PHW],
  input  logic signed [TW-1:0] sin_t [2**PHW],
  output logic signed [RW-1:0] rot_re,
  output logic signed [RW-1:0] rot_im
);
  localparam int PW = SW + TW;
  localparam int SH = TW - 1;
  localparam logic signed [PW:0] RND = (PW+1)'(1) <<< (SH - 1);

  logic signed [SW-1:0] a_q, b_q;
  logic signed [TW-1:0] c_q, s_q;
  logic signed [PW-1:0] ac_q, bs_q, as_q, bc_q;
  logic signed [PW-1:0] ac_d, bs_d, as_d, bc_d;
  logic signed [PW:0]   re_sum, im_sum;
  logic signed [RW-1:0] re_d, im_d;

  always_comb begin
    ac_d   = a_q * c_q;
    bs_d   = b_q * s_q;
    as_d   = a_q * s_q;
    bc_d   = b_q * c_q;
    re_sum = ac_q - bs_q;
    im_sum = as_q + bc_q;
    re_d   = RW'((re_sum + RND) >>> SH);
    im_d   = RW'((im_sum + RND) >>> SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; c_q <= '0; s_q <= '0;
      ac_q <= '0; bs_q <= '0; as_q <= '0; bc_q <= '0;
      rot_re <= '0; rot_im <= '0;
    end else begin
      if (ld_tab) begin
        a_q <= s_re;
        b_q <= s_im;
        c_q <= cos_t[phase];
        s_q <= sin_t[phase];
      end
      if (ld_mul) begin
        ac_q <= ac_d;
        bs_q <= bs_d;
        as_q <= as_d;
        bc_q <= bc_d;
      end
      if (ld_rnd) begin
        rot_re <= re_d;
        rot_im <= im_d;
      end
    end
  end
endmodule

// File: rtl/phs_adder_tree.sv
module phs_adder_tree #(
  parameter int N  = 32,
  parameter int IW = 9,
  localparam int LV = $clog2(N),
  localparam int OW = IW + LV
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LV-1:0]        lvl_en,
  input  logic signed [IW-1:0] din [N],
  output logic signed [OW-1:0] dout
);
  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int W = IW + l + 1;
    localparam int M = N >> (l + 1);
    logic signed [W-1:0] q [M];
    for (genvar k = 0; k < M; k++) begin : g_add
      logic signed [W-1:0] d;
      if (l == 0) begin : g_first
        always_comb d = W'(din[2*k]) + W'(din[2*k+1]);
      end else begin : g_next
        always_comb d = W'(g_lvl[l-1].q[2*k]) + W'(g_lvl[l-1].q[2*k+1]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q[k] <= '0;
        else if (lvl_en[l]) q[k] <= d;
      end
    end
  end

  assign dout = g_lvl[LV-1].q[0];
endmodule

// File: rtl/phase_summer.sv
module phase_summer #(
  parameter int NSTA = 32,
  parameter int SW   = 8,
  parameter int TW   = 8,
  parameter int PHW  = 8,
  parameter int ACCW = 16,
  parameter int RW   = 9,
  localparam int SELW = $clog2(NSTA),
  localparam int OW   = RW + $clog2(NSTA)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [NSTA*SW-1:0]     in_re,
  input  logic [NSTA*SW-1:0]     in_im,
  input  logic                   sync,
  input  logic                   wr_en,
  input  logic [SELW-1:0]        wr_sta,
  input  logic                   wr_sel,
  input  logic [ACCW-1:0]        wr_data,
  output logic                   out_valid,
  output logic signed [OW-1:0]   out_re,
  output logic signed [OW-1:0]   out_im
);
  localparam int LV  = $clog2(NSTA);
  localparam int LAT = 3 + LV;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // valid pipe: vld_q[k] marks stage k holding a sample
  logic [LAT:1] vld_q, vld_d;
  always_comb vld_d = {vld_q[LAT-1:1], in_valid};
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) vld_q <= '0;
    else          vld_q <= vld_d;
  end
  assign out_valid = vld_q[LAT];

  logic signed [TW-1:0] cos_t [2**PHW];
  logic signed [TW-1:0] sin_t [2**PHW];
  phs_trig_rom #(.PHW(PHW), .TW(TW)) u_rom (.cos_t(cos_t), .sin_t(sin_t));

  logic signed [RW-1:0] rot_re [NSTA];
  logic signed [RW-1:0] rot_im [NSTA];

  for (genvar i = 0; i < NSTA; i++) begin : g_sta
    logic           hit;
    logic [PHW-1:0] phase;
    assign hit = wr_en && (wr_sta == SELW'(i));

    phs_phase_gen #(.ACCW(ACCW), .PHW(PHW)) u_gen (
      .clk(clk), .rst_n(rst_i_n), .in_valid(in_valid), .sync(sync),
      .wr_rate(hit && !wr_sel), .wr_init(hit && wr_sel),
      .wr_data(wr_data), .phase(phase)
    );

    phs_rotator #(.SW(SW), .TW(TW), .PHW(PHW), .RW(RW)) u_rot (
      .clk(clk), .rst_n(rst_i_n),
      .ld_tab(in_valid), .ld_mul(vld_q[1]), .ld_rnd(vld_q[2]),
      .phase(phase),
      .s_re(in_re[i*SW +: SW]), .s_im(in_im[i*SW +: SW]),
      .cos_t(cos_t), .sin_t(sin_t),
      .rot_re(rot_re[i]), .rot_im(rot_im[i])
    );
  end

  logic [LV-1:0] tree_en;
  assign tree_en = vld_q[LAT-1:3];

  phs_adder_tree #(.N(NSTA), .IW(RW)) u_tree_re (
    .clk(clk), .rst_n(rst_i_n), .lvl_en(tree_en), .din(rot_re), .dout(out_re)
  );
  phs_adder_tree #(.N(NSTA), .IW(RW)) u_tree_im (
    .clk(clk), .rst_n(rst_i_n), .lvl_en(tree_en), .din(rot_im), .dout(out_im)
  );
endmodule

// File: rtl/phs_summer_chk.sv
module phs_summer_chk #(
  parameter int OW   = 14,
  parameter int NSTA = 32,
  parameter int RW   = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im
);
  localparam int BOUND = NSTA * (2 ** (RW - 1) - 1);

  logic [3:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt != 4'hf) cnt <= cnt + 4'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < 4'd8) |-> !out_valid);

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 4'd11) |-> (out_valid == $past(in_valid, 8)));

  a_r9_hold_re: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_re));

  a_r9_hold_im: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_im));

  a_r5_sum_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_re) <= BOUND && $signed(out_re) >= -BOUND &&
                   $signed(out_im) <= BOUND && $signed(out_im) >= -BOUND));
endmodule

bind phase_summer phs_summer_chk #(.OW(OW), .NSTA(NSTA), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/phase_summer_test.sv
`timescale 1ns/1ps
module phase_summer_test;
  localparam int NSTA = 32;
  localparam int SW   = 8;
  localparam int OW   = 14;
  localparam int LAT  = 8;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid, sync, wr_en, wr_sel;
  logic [NSTA*SW-1:0]   in_re, in_im;
  logic [4:0]           wr_sta;
  logic [15:0]          wr_data;
  logic                 out_valid;
  logic signed [OW-1:0] out_re, out_im;

  always #2.5 clk = ~clk;

  phase_summer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .sync(sync), .wr_en(wr_en), .wr_sta(wr_sta), .wr_sel(wr_sel), .wr_data(wr_data),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_on = 0;
  bit done = 0;

  int rate_m [NSTA];
  int init_m [NSTA];
  int acc_m  [NSTA];
  int sre    [NSTA];
  int sim    [NSTA];

  typedef struct { int re; int im; int stamp; } exp_t;
  exp_t exq [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // R3 table model
  function automatic int tsin(input int k);
    int p, m, q, den, v;
    p = k % 256;
    m = p % 128;
    q = m * (128 - m);
    den = 81920 - 4 * q;
    v = (127 * 16 * q + den / 2) / den;
    return (p >= 128) ? -v : v;
  endfunction
  function automatic int tcos(input int k);
    return tsin((k + 64) % 256);
  endfunction

  task automatic send(input bit sy);
    int er, ei, base, idx, c, s;
    @(negedge clk);
    in_valid = 1'b1; sync = sy; wr_en = 1'b0;
    er = 0; ei = 0;
    for (int i = 0; i < NSTA; i++) begin
      in_re[i*SW +: SW] = sre[i][7:0];
      in_im[i*SW +: SW] = sim[i][7:0];
      base = sy ? init_m[i] : acc_m[i];           // R6 R7
      idx = (base >> 8) & 255;
      c = tcos(idx); s = tsin(idx);
      er += (sre[i] * c - sim[i] * s + 64) >>> 7;  // R4
      ei += (sre[i] * s + sim[i] * c + 64) >>> 7;
      acc_m[i] = (base + rate_m[i]) & 16'hffff;
    end
    exq.push_back('{er, ei, cyc});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; sync = 1'b0; wr_en = 1'b0;
    end
  endtask

  task automatic sync_only();
    @(negedge clk);
    in_valid = 1'b0; sync = 1'b1; wr_en = 1'b0;
    for (int i = 0; i < NSTA; i++) acc_m[i] = init_m[i];  // R7
  endtask

  task automatic wr(input int sta, input bit sel, input int val);
    @(negedge clk);
    in_valid = 1'b0; sync = 1'b0;
    wr_en = 1'b1; wr_sta = 5'(sta); wr_sel = sel; wr_data = 16'(val);
    if (sel) init_m[sta] = val & 16'hffff; else rate_m[sta] = val & 16'hffff;  // R8
  endtask

  task automatic rand_samples();
    for (int i = 0; i < NSTA; i++) begin
      sre[i] = int'($urandom_range(255)) - 128;
      sim[i] = int'($urandom_range(255)) - 128;
    end
  endtask

  // scoreboard monitor
  int last_re = 0;
  int last_im = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exq.size() == 0) begin
          chk(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = exq.pop_front();
          chk(cyc == e.stamp + LAT, "R2 latency", cyc - e.stamp, LAT);
          chk(int'(out_re) == e.re, "R3 R4 R5 out_re", int'(out_re), e.re);
          chk(int'(out_im) == e.im, "R3 R4 R5 out_im", int'(out_im), e.im);
        end
      end else begin
        chk(int'(out_re) == last_re && int'(out_im) == last_im,
            "R9 hold while invalid", int'(out_re), last_re);
      end
      last_re = int'(out_re);
      last_im = int'(out_im);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; sync = 1'b0; wr_en = 1'b0; wr_sel = 1'b0;
    wr_sta = '0; wr_data = '0; in_re = '0; in_im = '0;
    for (int i = 0; i < NSTA; i++) begin rate_m[i] = 0; init_m[i] = 0; acc_m[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(out_re == '0 && out_im == '0, "R1 out data after reset", int'(out_re), 0);
    mon_on = 1'b1;

    // R1 R4: default phase 0, ramp and full-scale negative
    for (int i = 0; i < NSTA; i++) begin sre[i] = i * 4 - 64; sim[i] = 63 - i * 3; end
    send(1'b0);
    for (int i = 0; i < NSTA; i++) begin sre[i] = -128; sim[i] = -128; end
    send(1'b0);  // R5 extreme at phase 0
    idle(3);

    // R3 R6: distinct rates, back-to-back stream across all quadrants
    for (int i = 0; i < NSTA; i++) wr(i, 1'b0, i * 1237 + 300);
    for (int n = 0; n < 40; n++) begin rand_samples(); send(1'b0); end

    // R6 R9: irregular gaps, accumulators must hold while idle
    for (int n = 0; n < 12; n++) begin
      rand_samples(); send(1'b0); idle(1 + (n % 3));
    end

    // R7: sync with a valid sample, initial phases per station
    for (int i = 0; i < NSTA; i++) wr(i, 1'b1, i * 2048 + 17);
    rand_samples(); send(1'b1);
    for (int n = 0; n < 6; n++) begin rand_samples(); send(1'b0); end

    // R7: sync without a valid sample
    idle(2);
    sync_only();
    for (int n = 0; n < 6; n++) begin rand_samples(); send(1'b0); end

    // R8: one station's rate changed, an initial phase written without sync
    wr(5, 1'b0, 16'h4000);
    wr(9, 1'b1, 16'h8000);
    for (int n = 0; n < 8; n++) begin rand_samples(); send(1'b0); end
    sync_only();
    rand_samples(); send(1'b0);

    // R5: full-scale negative at phase 128 (cos = -127) gives the positive extreme
    for (int i = 0; i < NSTA; i++) begin wr(i, 1'b0, 0); wr(i, 1'b1, 16'h8000); end
    sync_only();
    for (int i = 0; i < NSTA; i++) begin sre[i] = -128; sim[i] = -128; end
    send(1'b0);
    for (int i = 0; i < NSTA; i++) begin sre[i] = 127; sim[i] = -128; end
    send(1'b0);

    idle(20);
    chk(exq.size() == 0, "R2 all outputs delivered", exq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule